// File: doc/BRIEF.md
# Multi-Width Sequential Integer Divider

This block divides a double-width dividend (high half and low half together) by a single-width divisor. It produces a quotient and a remainder in either unsigned or signed form. A two-bit size select picks a lane of 8, 16, 32 or 64 bits; the dividend is then twice that width. A one-cycle `start` pulse launches the operation. Later, a one-cycle `done` pulse presents the result, or it raises `err` instead. Signed operation works on magnitudes: the operand signs are stripped before the shift-subtract loop and applied again afterwards.

The block has one divide error. It covers a zero divisor and also any quotient that cannot be represented at the chosen width. Most overflows are found before any iteration, by comparing the upper half of the dividend magnitude with the divisor magnitude. That early check leaves one case open: a signed quotient whose magnitude fits the width without a sign bit. This case is caught after the loop. The signed range is asymmetric, so a negative quotient may reach half the lane range in magnitude but a positive one may not.

Top module: `wide_divider`

## Requirements
- R1: When a start is accepted and the divisor, masked to the lane width, is zero, `done` and `err` are high in the cycle after the start edge.
- R2: For an unsigned division without error, the quotient and remainder of the masked dividend and divisor appear with `done` N+1 cycles after the start edge, where N is the lane width.
- R3: For an unsigned division whose dividend high half is greater than or equal to the divisor, `done` and `err` are high in the cycle after the start edge.
- R4: In signed mode, the quotient is truncated toward zero and the remainder carries the sign of the dividend, both in two's complement at the lane width.
- R5: In signed mode, a quotient of -2^(N-1) is a valid result. A quotient of +2^(N-1), or any value outside [-2^(N-1), 2^(N-1)-1], is flagged with `err` on the `done` pulse N+1 cycles after the start edge.
- R6: Whenever `done` and `err` are high together, `quotient` and `remainder` are zero.
- R7: `byte_pack` carries the remainder in bits 15:8 and the quotient in bits 7:0. It gives the 8-bit lane result (size select 0) in packed form.
- R8: `busy` is high from the accepted start until the cycle that brings `done`. It is never high together with `done`, and a `start` while `busy` is high is ignored.
- R9: Dividend bits at or above 2N and divisor bits at or above N are ignored. Output bits at or above N are zero. Size select: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R10: After reset, `done`, `busy`, `err`, `quotient` and `remainder` are zero. `done` lasts one cycle for each result, and `quotient` and `remainder` hold their values between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a division when idle |
| is_signed | input | 1 | 1 selects two's complement division |
| size_sel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| dividend | input | 2*W | Double-width dividend, high half above low half |
| divisor | input | W | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Divide error, valid with `done` |
| quotient | output | W | Quotient, zero-extended from the lane |
| remainder | output | W | Remainder, zero-extended from the lane |
| byte_pack | output | 16 | Remainder and quotient of the 8-bit lane, packed |

## Verification
A wrong partial remainder or a misplaced quotient bit inside the loop shows only once, as a wrong `quotient` or `remainder` on the `done` pulse N+1 cycles after start. A stray step count shows at once as `done` or `busy` arriving in the wrong cycle. A wrong latched sign or size shows as a result with the wrong sign, or as a missed or false signed-overflow error, on that same `done` pulse. The bench compares `done`, `busy` and both result ports against its model on every clock, so any of these faults is reported in the cycle where it first reaches the ports.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dstate_e;

  // Lane width in bits for a size code, given the widest lane w.
  function automatic int lane_bits(input int w, input logic [1:0] code);
    return w >> (3 - int'(code));
  endfunction

endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep
  import wdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic [1:0]     size_sel,
  input  logic           is_signed,
  output logic [W-1:0]   hi_mag,
  output logic [W-1:0]   lo_top,
  output logic [W-1:0]   dvs_mag,
  output logic           dvd_neg,
  output logic           dvs_neg,
  output logic           dvs_zero,
  output logic           pre_ovf
);

  localparam logic [2*W-1:0] ONE_D = {{(2*W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0]   ONE_S = {{(W-1){1'b0}}, 1'b1};

  int               n;
  logic [2*W-1:0]   m_dvd, top_dvd, dv, dmag;
  logic [W-1:0]     m_dvs, top_dvs, ds;

  // Lane masks and sign-bit selectors derived from the size code.
  always_comb begin
    n = lane_bits(W, size_sel);
    for (int i = 0; i < 2*W; i++) begin
      m_dvd[i]   = (i < 2*n);
      top_dvd[i] = (i == 2*n - 1);
    end
    for (int i = 0; i < W; i++) begin
      m_dvs[i]   = (i < n);
      top_dvs[i] = (i == n - 1);
    end
  end

  // Magnitudes, alignment of the low half and the up-front checks.
  always_comb begin
    dv       = dividend & m_dvd;
    ds       = divisor & m_dvs;
    dvd_neg  = is_signed & (|(dv & top_dvd));
    dvs_neg  = is_signed & (|(ds & top_dvs));
    dmag     = dvd_neg ? ((~dv + ONE_D) & m_dvd) : dv;
    dvs_mag  = dvs_neg ? ((~ds + ONE_S) & m_dvs) : ds;
    hi_mag   = W'(dmag >> n);
    lo_top   = W'(dmag << (W - n));
    dvs_zero = (ds == '0);
    pre_ovf  = (hi_mag >= dvs_mag);
  end

endmodule

// File: rtl/wdiv_core.sv
module wdiv_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);

  logic [W-1:0] dvs_q;
  logic [W-1:0] hi_n, lo_n, dvs_n;
  logic [W:0]   trial, diff;
  logic         fits;

  // One restoring step: shift in the next dividend bit, subtract if possible.
  always_comb begin
    trial = {hi_q, lo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
    hi_n  = hi_q;
    lo_n  = lo_q;
    dvs_n = dvs_q;
    if (load) begin
      hi_n  = hi_in;
      lo_n  = lo_in;
      dvs_n = dvs_in;
    end else if (step) begin
      hi_n = fits ? diff[W-1:0] : trial[W-1:0];
      lo_n = {lo_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dvs_q <= '0;
    end else if (load || step) begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      dvs_q <= dvs_n;
    end
  end

  AST_PARTIAL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (hi_q < dvs_q)); // R2

endmodule

// File: rtl/wdiv_fix.sv
module wdiv_fix
  import wdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] rmag,
  input  logic [1:0]   size_sel,
  input  logic         is_signed,
  input  logic         dvd_neg,
  input  logic         dvs_neg,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         post_ovf
);

  localparam logic [W-1:0] ONE_S = {{(W-1){1'b0}}, 1'b1};

  int           n;
  logic [W-1:0] m_lane, qm, rm, lim;
  logic         q_neg;

  always_comb begin
    n = lane_bits(W, size_sel);
    for (int i = 0; i < W; i++) begin
      m_lane[i] = (i < n);
    end
    qm    = qmag & m_lane;
    rm    = rmag & m_lane;
    lim   = ONE_S << (n - 1);
    q_neg = dvd_neg ^ dvs_neg;
    // Asymmetric signed range: negative side may reach lim, positive may not.
    post_ovf = is_signed & (q_neg ? (qm > lim) : (qm >= lim));
    quot     = q_neg   ? ((~qm + ONE_S) & m_lane) : qm;
    rem      = dvd_neg ? ((~rm + ONE_S) & m_lane) : rm;
  end

endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic [1:0]     size_sel,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic [15:0]    byte_pack
);

  localparam int CW = $clog2(W);

  // Reset: asserted asynchronously, released on the clock.
  logic rs_a, rs_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  dstate_e       state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    sz_q, sz_n;
  logic          sgn_q, sgn_n, dneg_q, dneg_n, sneg_q, sneg_n;
  logic          done_q, done_n, err_q, err_n;
  logic [W-1:0]  quot_q, quot_n, rem_q, rem_n;

  logic [W-1:0]  hi_mag, lo_top, dvs_mag, core_hi, core_lo, fix_q, fix_r;
  logic          dvd_neg, dvs_neg, dvs_zero, pre_ovf, post_ovf;
  logic          accept, load, step;

  wdiv_prep #(.W(W)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .size_sel (size_sel),
    .is_signed(is_signed),
    .hi_mag   (hi_mag),
    .lo_top   (lo_top),
    .dvs_mag  (dvs_mag),
    .dvd_neg  (dvd_neg),
    .dvs_neg  (dvs_neg),
    .dvs_zero (dvs_zero),
    .pre_ovf  (pre_ovf)
  );

  wdiv_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rs_b),
    .load  (load),
    .step  (step),
    .hi_in (hi_mag),
    .lo_in (lo_top),
    .dvs_in(dvs_mag),
    .hi_q  (core_hi),
    .lo_q  (core_lo)
  );

  wdiv_fix #(.W(W)) u_fix (
    .qmag     (core_lo),
    .rmag     (core_hi),
    .size_sel (sz_q),
    .is_signed(sgn_q),
    .dvd_neg  (dneg_q),
    .dvs_neg  (sneg_q),
    .quot     (fix_q),
    .rem      (fix_r),
    .post_ovf (post_ovf)
  );

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sz_n    = sz_q;
    sgn_n   = sgn_q;
    dneg_n  = dneg_q;
    sneg_n  = sneg_q;
    done_n  = 1'b0;
    err_n   = err_q;
    quot_n  = quot_q;
    rem_n   = rem_q;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          sz_n   = size_sel;
          sgn_n  = is_signed;
          dneg_n = dvd_neg;
          sneg_n = dvs_neg;
          if (dvs_zero || pre_ovf) begin
            done_n = 1'b1;
            err_n  = 1'b1;
            quot_n = '0;
            rem_n  = '0;
          end else begin
            load    = 1'b1;
            cnt_n   = CW'(lane_bits(W, size_sel) - 1);
            state_n = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (cnt_q == '0) state_n = ST_FIN;
        else             cnt_n   = cnt_q - 1'b1;
      end
      ST_FIN: begin
        done_n  = 1'b1;
        err_n   = post_ovf;
        quot_n  = post_ovf ? '0 : fix_q;
        rem_n   = post_ovf ? '0 : fix_r;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_b) begin
    if (!rs_b) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sz_q    <= '0;
      sgn_q   <= 1'b0;
      dneg_q  <= 1'b0;
      sneg_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sz_q    <= sz_n;
      sgn_q   <= sgn_n;
      dneg_q  <= dneg_n;
      sneg_q  <= sneg_n;
      done_q  <= done_n;
      err_q   <= err_n;
      quot_q  <= quot_n;
      rem_q   <= rem_n;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign quotient  = quot_q;
  assign remainder = rem_q;
  assign byte_pack = {rem_q[7:0], quot_q[7:0]};

  AST_ZERO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dvs_zero) |=> (done && err)); // R1
  AST_EARLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dvs_zero && pre_ovf) |=> (done && err)); // R3
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (quotient == '0 && remainder == '0)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder))); // R10

endmodule

// File: tb/wide_divider_test.sv
module wide_divider_test;

  localparam int W = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           is_signed = 1'b0;
  logic [1:0]     size_sel = 2'd0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic           busy, done, err;
  logic [W-1:0]   quotient, remainder;
  logic [15:0]    byte_pack;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;

  always #5 clk = ~clk;

  wide_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .size_sel(size_sel), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .err(err), .quotient(quotient),
    .remainder(remainder), .byte_pack(byte_pack)
  );

  // Reference model state.
  bit        m_busy, m_done, m_err, p_err;
  int        m_cnt;
  logic [63:0] m_q, m_r, p_q, p_r;
  logic [1:0]  m_sz;
  string       m_tag = "R10";

  task automatic compute(input bit sg, input logic [1:0] code,
                         input logic [127:0] dvd, input logic [63:0] dvs,
                         output bit early, output bit e,
                         output logic [63:0] q, output logic [63:0] r);
    int n;
    logic [135:0] a_u, b_u, mk2, mk1;
    logic signed [135:0] sa, sb, sq, sr, aq, half, full;
    n   = 8 << code;
    mk2 = (136'd1 << (2*n)) - 136'd1;
    mk1 = (136'd1 << n) - 136'd1;
    a_u = {8'd0, dvd} & mk2;
    b_u = {72'd0, dvs} & mk1;
    if (sg && a_u[2*n-1]) a_u = a_u | ~mk2;
    if (sg && b_u[n-1])   b_u = b_u | ~mk1;
    early = 1'b0; e = 1'b0; q = '0; r = '0;
    if (b_u == '0) begin
      early = 1'b1; e = 1'b1;
      return;
    end
    sa = a_u; sb = b_u;
    sq = sa / sb; sr = sa % sb;
    aq = (sq < 0) ? -sq : sq;
    full = 136'sd1 <<< n;
    half = 136'sd1 <<< (n-1);
    if (aq >= full) begin
      early = 1'b1; e = 1'b1;
    end else if (sg && (sq >= half || sq < -half)) begin
      e = 1'b1;
    end else begin
      q = 64'(sq & mk1);
      r = 64'(sr & mk1);
    end
  endtask

  always @(posedge clk) begin
    bit was_busy, early;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_q = '0; m_r = '0;
    end else begin
      was_busy = m_busy;
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1;
          m_err = p_err; m_q = p_q; m_r = p_r;
        end
      end
      if (!was_busy && start) begin
        m_sz = size_sel;
        compute(is_signed, size_sel, dividend, divisor, early, p_err, p_q, p_r);
        if (early) begin
          m_done = 1'b1; m_err = 1'b1; m_q = '0; m_r = '0;
        end else begin
          m_busy = 1'b1;
          m_cnt = (8 << size_sel) + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      chk(m_tag, done == m_done, 64'(done), 64'(m_done), "done");
      chk("R8", busy == m_busy, 64'(busy), 64'(m_busy), "busy");
      chk(m_done ? m_tag : "R10", quotient == m_q, quotient, m_q, "quotient");
      chk(m_done ? m_tag : "R10", remainder == m_r, remainder, m_r, "remainder");
      if (m_done) begin
        chk(m_tag, err == m_err, 64'(err), 64'(m_err), "err");
        if (m_sz == 2'd0)
          chk("R7", byte_pack == {m_r[7:0], m_q[7:0]}, 64'(byte_pack),
              64'({m_r[7:0], m_q[7:0]}), "byte_pack");
      end
    end
  end

  task automatic run(input string tag, input bit sg, input logic [1:0] code,
                     input logic [127:0] dvd, input logic [63:0] dvs);
    @(negedge clk);
    m_tag = tag;
    is_signed = sg; size_sel = code; dividend = dvd; divisor = dvs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", done == 1'b0 && busy == 1'b0 && err == 1'b0, 64'({done, busy, err}), 64'd0, "reset flags");
    chk("R10", quotient == '0 && remainder == '0, quotient | remainder, 64'd0, "reset results");
    chk_on = 1'b1;

    run("R2", 0, 2'd0, 128'd1000, 64'd7);
    run("R2", 0, 2'd1, 128'h0001_2345, 64'h0123);
    run("R2", 0, 2'd2, 128'h0123_4567_89AB_CDEF, 64'h9876_5432);
    run("R2", 0, 2'd3, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, 64'hF000_0000_0000_0001);
    run("R1", 0, 2'd0, 128'd1000, 64'd0);
    run("R1", 1, 2'd2, 128'd5, 64'd0);
    run("R9", 0, 2'd0, {112'hA5A5_0000_1111_2222_3333_4444_5555, 16'h03E8}, {56'hFF_EEDD_CCBB_AA99, 8'd7});
    run("R9", 1, 2'd0, 128'd5, 64'h100);
    run("R3", 0, 2'd0, 128'h0700, 64'd7);
    run("R3", 0, 2'd3, {64'd5, 64'd0}, 64'd5);
    run("R6", 1, 2'd1, 128'h4000_0000, 64'd2);
    run("R4", 1, 2'd0, 128'hFF9C, 64'd7);
    run("R4", 1, 2'd1, 128'd1000, 64'hFFF9);
    run("R4", 1, 2'd2, 128'hFFFF_FFFF_FFFF_FC18, 64'hFFFF_FFF9);
    run("R4", 1, 2'd3, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FC18}, 64'hFFFF_FFFF_FFFF_FFF9);
    run("R5", 1, 2'd0, 128'hFF00, 64'd2);
    run("R5", 1, 2'd0, 128'h0100, 64'd2);
    run("R5", 1, 2'd0, 128'h0100, 64'hFE);
    run("R5", 1, 2'd3, {64'd0, 64'h8000_0000_0000_0000}, 64'd1);
    run("R7", 0, 2'd0, 128'd255, 64'd16);

    // R8: a second start while busy must be ignored.
    @(negedge clk);
    m_tag = "R8";
    is_signed = 1'b0; size_sel = 2'd1; dividend = 128'd50000; divisor = 64'd300;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = 128'd9; divisor = 64'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    repeat (3) @(negedge clk);

    chk_on = 1'b0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule